// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of finished conversion results from an ADC. Each result arrives as a 32-bit word, a channel tag and a one-cycle valid strobe. Results from the first eight channels are tested against a programmable low threshold and a programmable high threshold. Five condition enables choose which relations count as a hit: below the low threshold, at or above the low threshold, below the high threshold, at or above the high threshold, and inside the window. A result raises an event when any enabled condition holds.

An event sets a sticky status flag and stores the channel tag of the result that caused it. The flag holds until software reads the channel field or disables the block. The interrupt output follows the flag whenever the interrupt enable is set. All control inputs come from an outside register file, which is also where the read strobe comes from.

Top module: `adc_win_cmp`

## Requirements
- R1: After reset, `evt_flag`, `evt_chan` and `irq` are all 0.
- R2: Condition enable bit 0 (below-low) gives a hit when the sample is less than `cfg_lo_thr`. A sample equal to the threshold gives no hit.
- R3: Condition enable bit 1 (at-or-above-low) gives a hit when the sample is greater than or equal to `cfg_lo_thr`.
- R4: Condition enable bit 2 (below-high) gives a hit when the sample is less than `cfg_hi_thr`.
- R5: Condition enable bit 3 (at-or-above-high) gives a hit when the sample is greater than or equal to `cfg_hi_thr`.
- R6: Condition enable bit 4 (inside-window) gives a hit when `cfg_lo_thr` <= sample < `cfg_hi_thr`. All comparisons are unsigned, and the 16-bit thresholds are zero-extended to 32 bits.
- R7: An event is the OR of all enabled hits. With every condition enable at 0, no sample raises an event.
- R8: Only samples tagged with channel codes 0 to 7 are evaluated. Codes 8 to 31 never raise an event.
- R9: While `evt_flag` is 1, later matching samples do not change `evt_chan` and do not re-trigger the flag.
- R10: A pulse on `id_rd` clears `evt_flag` at the next clock edge. If a matching sample arrives in the same cycle, the new event wins: the flag stays 1 and `evt_chan` takes the new channel.
- R11: While `cfg_en` is 0, the flag is cleared at each clock edge and no sample raises an event.
- R12: `irq` is 1 exactly while `evt_flag` is 1 and `cfg_irq_en` is 1, with no added delay.
- R13: A sample is evaluated only on the edge where `smp_valid` is 1. Its event is visible on `evt_flag` and `evt_chan` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Comparator enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_cond_en | input | 5 | Condition enables (bit 0 below-low, 1 at-or-above-low, 2 below-high, 3 at-or-above-high, 4 inside-window) |
| cfg_lo_thr | input | 16 | Low threshold |
| cfg_hi_thr | input | 16 | High threshold |
| id_rd | input | 1 | One-cycle strobe: the channel field is being read |
| smp_valid | input | 1 | Sample valid strobe |
| smp_chan | input | 5 | Channel tag of the sample |
| smp_data | input | 32 | Sample value |
| evt_flag | output | 1 | Sticky event status |
| evt_chan | output | 5 | Channel tag captured at the last event |
| irq | output | 1 | Interrupt request |

## Verification
A valid sample, a clearing read or a disable all take effect on `evt_flag` and `evt_chan` at the first rising edge. `irq` follows the flag and `cfg_irq_en` in the same cycle. The bench changes its inputs 1 ns after a falling edge. It compares the outputs at the falling edge that follows the next rising edge, so each sample's result is read exactly one edge later. A behavioural model in the bench is updated on the same rising edges and is compared against the design on every falling edge. The scripted checks sample the outputs before the next stimulus is applied.

// File: rtl/adc_wcmp_pkg.sv
`timescale 1ns/1ps
package adc_wcmp_pkg;
  localparam int unsigned N_COND = 5;

  typedef enum int unsigned {
    C_BELOW_LO   = 0,
    C_ATLEAST_LO = 1,
    C_BELOW_HI   = 2,
    C_ATLEAST_HI = 3,
    C_INSIDE     = 4
  } cond_e;

  // Map the two magnitude results onto the five condition bits.
  function automatic logic [N_COND-1:0] cond_from_cmp(input logic ge_lo, input logic ge_hi);
    logic [N_COND-1:0] v;
    v[C_BELOW_LO]   = !ge_lo;
    v[C_ATLEAST_LO] = ge_lo;
    v[C_BELOW_HI]   = !ge_hi;
    v[C_ATLEAST_HI] = ge_hi;
    v[C_INSIDE]     = ge_lo && !ge_hi;
    return v;
  endfunction
endpackage

// File: rtl/wcmp_mag.sv
`timescale 1ns/1ps
module wcmp_mag #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned THR_W  = 16
) (
  input  logic [DATA_W-1:0] data,
  input  logic [THR_W-1:0]  lo_thr,
  input  logic [THR_W-1:0]  hi_thr,
  output logic              ge_lo,
  output logic              ge_hi
);
  localparam int unsigned CMP_W = (DATA_W > THR_W) ? DATA_W : THR_W;

  logic [CMP_W-1:0] d_x, lo_x, hi_x;

  // Unsigned compare on a common width, both sides zero-extended.
  assign d_x  = CMP_W'(data);
  assign lo_x = CMP_W'(lo_thr);
  assign hi_x = CMP_W'(hi_thr);

  assign ge_lo = (d_x >= lo_x);
  assign ge_hi = (d_x >= hi_x);
endmodule

// File: rtl/wcmp_match.sv
`timescale 1ns/1ps
module wcmp_match
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned NUM_MON = 8
) (
  input  logic              en,
  input  logic              valid,
  input  logic [CHAN_W-1:0] chan,
  input  logic              ge_lo,
  input  logic              ge_hi,
  input  logic [N_COND-1:0] cond_en,
  output logic              chan_ok,
  output logic              match
);
  logic [N_COND-1:0] raw;
  logic [N_COND-1:0] hit;

  assign raw     = cond_from_cmp(ge_lo, ge_hi);
  assign chan_ok = (int'(chan) < int'(NUM_MON));

  for (genvar i = 0; i < N_COND; i++) begin : g_cond
    assign hit[i] = raw[i] & cond_en[i];
  end

  assign match = en && valid && chan_ok && (|hit);
endmodule

// File: rtl/wcmp_status.sv
`timescale 1ns/1ps
module wcmp_status #(
  parameter int unsigned CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              match,
  input  logic [CHAN_W-1:0] chan,
  input  logic              rd,
  output logic              flag,
  output logic [CHAN_W-1:0] chan_q
);
  logic capture;

  // A new match is taken when the flag is free or is being cleared now.
  assign capture = match && (!flag || rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      chan_q <= '0;
    end else if (!en) begin
      flag   <= 1'b0;
    end else if (capture) begin
      flag   <= 1'b1;
      chan_q <= chan;
    end else if (rd) begin
      flag   <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_win_cmp.sv
`timescale 1ns/1ps
module adc_win_cmp
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_W   = 16,
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned NUM_MON = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_irq_en,
  input  logic [4:0]        cfg_cond_en,
  input  logic [THR_W-1:0]  cfg_lo_thr,
  input  logic [THR_W-1:0]  cfg_hi_thr,
  input  logic              id_rd,
  input  logic              smp_valid,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic [DATA_W-1:0] smp_data,
  output logic              evt_flag,
  output logic [CHAN_W-1:0] evt_chan,
  output logic              irq
);
  logic ge_lo, ge_hi;
  logic chan_ok;
  logic match_hit;

  wcmp_mag #(.DATA_W(DATA_W), .THR_W(THR_W)) u_mag (
    .data   (smp_data),
    .lo_thr (cfg_lo_thr),
    .hi_thr (cfg_hi_thr),
    .ge_lo  (ge_lo),
    .ge_hi  (ge_hi)
  );

  wcmp_match #(.CHAN_W(CHAN_W), .NUM_MON(NUM_MON)) u_match (
    .en      (cfg_en),
    .valid   (smp_valid),
    .chan    (smp_chan),
    .ge_lo   (ge_lo),
    .ge_hi   (ge_hi),
    .cond_en (cfg_cond_en),
    .chan_ok (chan_ok),
    .match   (match_hit)
  );

  wcmp_status #(.CHAN_W(CHAN_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_en),
    .match  (match_hit),
    .chan   (smp_chan),
    .rd     (id_rd),
    .flag   (evt_flag),
    .chan_q (evt_chan)
  );

  assign irq = evt_flag & cfg_irq_en;
endmodule

// File: rtl/adc_win_cmp_chk.sv
`timescale 1ns/1ps
module adc_win_cmp_chk #(
  parameter int unsigned CHAN_W  = 5,
  parameter int unsigned NUM_MON = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              id_rd,
  input logic              smp_valid,
  input logic [CHAN_W-1:0] smp_chan,
  input logic              chan_ok,
  input logic              match_hit,
  input logic              evt_flag,
  input logic [CHAN_W-1:0] evt_chan
);
  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !evt_flag);

  p_hold_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && cfg_en && !id_rd) |=> (evt_flag && $stable(evt_chan)));

  p_capture_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && (!evt_flag || id_rd)) |=> (evt_flag && evt_chan == $past(smp_chan)));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && !match_hit) |=> !evt_flag);

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(match_hit && smp_valid));

  p_unmonitored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !chan_ok) |-> !match_hit);

  p_chan_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag |-> (int'(evt_chan) < int'(NUM_MON)));
endmodule

bind adc_win_cmp adc_win_cmp_chk #(.CHAN_W(CHAN_W), .NUM_MON(NUM_MON)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .id_rd     (id_rd),
  .smp_valid (smp_valid),
  .smp_chan  (smp_chan),
  .chan_ok   (chan_ok),
  .match_hit (match_hit),
  .evt_flag  (evt_flag),
  .evt_chan  (evt_chan)
);

// File: tb/adc_win_cmp_test.sv
`timescale 1ns/1ps
module adc_win_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_irq_en = 1'b0, id_rd = 1'b0, smp_valid = 1'b0;
  logic [4:0]  cfg_cond_en = '0, smp_chan = '0;
  logic [15:0] cfg_lo_thr = '0, cfg_hi_thr = '0;
  logic [31:0] smp_data = '0;
  logic        evt_flag, irq;
  logic [4:0]  evt_chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  adc_win_cmp uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
    .cfg_cond_en(cfg_cond_en), .cfg_lo_thr(cfg_lo_thr), .cfg_hi_thr(cfg_hi_thr),
    .id_rd(id_rd), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .evt_flag(evt_flag), .evt_chan(evt_chan), .irq(irq)
  );

  // Behavioural reference model
  bit       m_flag;
  bit [4:0] m_chan;

  function automatic bit ref_hit(longint unsigned d, longint unsigned lo, longint unsigned hi, bit [4:0] ce);
    bit any = 0;
    if (ce[0] && d <  lo) any = 1;
    if (ce[1] && d >= lo) any = 1;
    if (ce[2] && d <  hi) any = 1;
    if (ce[3] && d >= hi) any = 1;
    if (ce[4] && d >= lo && d < hi) any = 1;
    return any;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0;
      m_chan = 0;
    end else begin
      bit hit;
      hit = cfg_en && smp_valid && (smp_chan <= 5'd7) &&
            ref_hit(longint'(smp_data), longint'(cfg_lo_thr), longint'(cfg_hi_thr), cfg_cond_en);
      if (!cfg_en) m_flag = 0;
      else if (hit && (!m_flag || id_rd)) begin
        m_flag = 1;
        m_chan = smp_chan;
      end else if (id_rd) m_flag = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R12 irq, R13 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R13 model flag", {31'd0, evt_flag}, {31'd0, m_flag});
      chk("R13 model chan", {27'd0, evt_chan}, {27'd0, m_chan});
      chk("R12 model irq", {31'd0, irq}, {31'd0, m_flag & cfg_irq_en});
    end
  end

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic smp(input logic [4:0] ch, input logic [31:0] d);
    smp_valid = 1; smp_chan = ch; smp_data = d;
    nxt();
    smp_valid = 0;
  endtask

  task automatic rd();
    id_rd = 1;
    nxt();
    id_rd = 0;
  endtask

  task automatic expect_evt(string tag, bit f, logic [4:0] ch);
    chk(tag, {31'd0, evt_flag}, {31'd0, f});
    if (f) chk(tag, {27'd0, evt_chan}, {27'd0, ch});
  endtask

  // Clear any event and try one sample with a given condition set
  task automatic probe(string tag, bit [4:0] ce, logic [31:0] d, bit exp_f);
    rd();
    cfg_cond_en = ce;
    smp(5'd3, d);
    expect_evt(tag, exp_f, 5'd3);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    nxt(); nxt();
    chk("R1 flag", {31'd0, evt_flag}, 0);
    chk("R1 chan", {27'd0, evt_chan}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rst_n = 1;
    nxt();
    chk("R1 after release", {31'd0, evt_flag}, 0);

    cfg_en = 1; cfg_lo_thr = 16'd100; cfg_hi_thr = 16'd200;
    // R2 below-low
    probe("R2 below", 5'b00001, 32'd99, 1);
    chk("R12 irq masked", {31'd0, irq}, 0);
    cfg_irq_en = 1; #0.1;
    chk("R12 irq on", {31'd0, irq}, 1);
    probe("R2 equal", 5'b00001, 32'd100, 0);
    chk("R12 irq off after clear", {31'd0, irq}, 0);
    // R3 at-or-above-low
    probe("R3 equal", 5'b00010, 32'd100, 1);
    probe("R3 below", 5'b00010, 32'd99, 0);
    // R4 below-high
    probe("R4 below", 5'b00100, 32'd199, 1);
    probe("R4 equal", 5'b00100, 32'd200, 0);
    // R5 at-or-above-high
    probe("R5 equal", 5'b01000, 32'd200, 1);
    probe("R5 below", 5'b01000, 32'd199, 0);
    // R6 inside window
    probe("R6 low edge", 5'b10000, 32'd100, 1);
    probe("R6 top-1", 5'b10000, 32'd199, 1);
    probe("R6 top", 5'b10000, 32'd200, 0);
    probe("R6 under", 5'b10000, 32'd99, 0);
    probe("R6 zero-extend", 5'b10000, 32'h0001_0064, 0);
    cfg_lo_thr = 16'hFFF0; cfg_hi_thr = 16'hFFFF;
    probe("R6 unsigned", 5'b10000, 32'h0000_FFF5, 1);
    cfg_lo_thr = 16'd100; cfg_hi_thr = 16'd200;
    // R7 OR and no-enable
    probe("R7 none enabled", 5'b00000, 32'd5, 0);
    probe("R7 OR hi", 5'b01001, 32'd250, 1);
    probe("R7 OR lo", 5'b01001, 32'd50, 1);
    probe("R7 OR miss", 5'b01001, 32'd150, 0);
    // R8 unmonitored channels
    rd(); cfg_cond_en = 5'b00001;
    smp(5'd8, 32'd1);
    expect_evt("R8 chan 8", 0, 0);
    smp(5'd31, 32'd1);
    expect_evt("R8 chan 31", 0, 0);
    smp(5'd7, 32'd1);
    expect_evt("R8 chan 7", 1, 5'd7);
    // R9 sticky
    rd();
    smp(5'd2, 32'd1);
    smp(5'd5, 32'd1);
    expect_evt("R9 hold chan", 1, 5'd2);
    nxt(); nxt();
    expect_evt("R9 still set", 1, 5'd2);
    // R10 read with simultaneous match
    id_rd = 1;
    smp(5'd6, 32'd1);
    id_rd = 0;
    expect_evt("R10 new wins", 1, 5'd6);
    rd();
    expect_evt("R10 read clears", 0, 0);
    // R13 no valid, no evaluation
    smp_chan = 5'd4; smp_data = 32'd1; smp_valid = 0;
    nxt(); nxt();
    expect_evt("R13 no valid", 0, 0);
    // R11 disable
    smp(5'd1, 32'd1);
    expect_evt("R11 pre", 1, 5'd1);
    cfg_en = 0;
    nxt();
    expect_evt("R11 cleared", 0, 0);
    smp(5'd1, 32'd1);
    expect_evt("R11 blocked", 0, 0);
    chk("R12 irq with disabled", {31'd0, irq}, 0);
    cfg_en = 1;
    nxt();
    expect_evt("R11 re-enable idle", 0, 0);

    nxt();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule